// File: doc/BRIEF.md
# DRAM refresh request interval timer

This block paces CAS-before-RAS refresh requests for a pair of DRAM banks. Software programs an 8-bit interval value and turns on one or both bank enable bits. That loads a down-counter from the interval, and the counter then steps down once for each pulse of an external time-base tick strobe. The system clock alone does not advance it.

When the count reaches zero, the block raises a refresh request and keeps it high. While the request is pending the counter stays at zero. The memory controller carries out the refresh and answers with a one-cycle done pulse. On that pulse the request drops and the counter reloads from the interval register, so a new countdown begins. The interval register, the counter and the enable bits all sit on a small register bus. Software can therefore also overwrite the running count directly.

Top module: `refresh_pacer`

## Requirements
- R1: After reset the interval register and the counter both read 0xFF, the enable register reads 0x00 and `refresh_req` is low.
- R2: The bus map is: address 0 is the interval register, address 1 is the counter, address 2 holds the enable bits in bits 1:0 (bit 0 is bank A, bit 1 is bank B), and address 3 reads 0. Each readable location returns what was last written to it, and the read is combinational on `bus_addr`.
- R3: A write to address 2 that sets either enable bit to 1 loads the counter from the interval register at that clock edge.
- R4: While at least one enable bit is 1 and no request is pending, the counter falls by one on each edge where `tick` is high, and only on such edges.
- R5: On the edge after the counter holds 0 with at least one enable bit set, `refresh_req` goes high. It stays high until `refresh_done` is seen.
- R6: While `refresh_req` is high, ticks do not change the counter, which stays at 0.
- R7: On the edge where `refresh_done` is high while a request is pending, `refresh_req` falls and the counter reloads from the interval register.
- R8: With both enable bits at 0, the counter ignores ticks and no new request is raised, including after an outstanding request has completed.
- R9: A write to address 1 replaces the count at once, and later ticks decrement from the written value.
- R10: A write to the interval register leaves the current count untouched and is used only at the next reload.
- R11: When a reload and a tick fall in the same cycle, the reload wins, so the counter holds the full interval afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base strobe that steps the counter |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write enable for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| refresh_req | output | 1 | Refresh request, held until done |
| refresh_done | input | 1 | One-cycle pulse that marks the refresh as complete |

## Verification
The counter is driven through several patterns:
- A plain countdown from a small interval shows that ticks alone move the count and that the zero detect raises the request one edge later.
- Ticks sent while the request is pending separate stalling at zero from wrapping to 0xFF.
- An overwrite of the count in mid-run and a change of the interval in mid-run show which of the two values the counter follows.
- An enable write and a tick in the same cycle show which of the two has priority.
- Ticks with both enables off, and a request completed after the enables were cleared, separate a halted timer from one that keeps refreshing.

// File: rtl/refresh_pacer.sv
module refresh_pacer #(
  parameter int CNT_W = 8,
  parameter int BANKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             refresh_req,
  input  logic             refresh_done
);
  localparam logic [CNT_W-1:0] RST_VAL = '1;

  logic [CNT_W-1:0] interval;
  logic [CNT_W-1:0] count;
  logic [BANKS-1:0] bank_en;

  logic wr_ival, wr_cnt, wr_en, start, active, reload, load_evt;

  assign wr_ival  = bus_we && bus_addr == 2'd0;
  assign wr_cnt   = bus_we && bus_addr == 2'd1;
  assign wr_en    = bus_we && bus_addr == 2'd2;
  assign start    = wr_en && |bus_wdata[BANKS-1:0];
  assign active   = |bank_en;
  assign reload   = refresh_req && refresh_done;
  assign load_evt = wr_cnt || start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      interval <= RST_VAL;
      bank_en  <= '0;
    end else begin
      if (wr_ival) interval <= bus_wdata;
      if (wr_en)   bank_en  <= bus_wdata[BANKS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= RST_VAL;
    else if (wr_cnt)
      count <= bus_wdata;
    else if (start || reload)
      count <= interval;
    else if (tick && active && !refresh_req && count != '0)
      count <= count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      refresh_req <= 1'b0;
    else if (refresh_req) begin
      if (refresh_done) refresh_req <= 1'b0;
    end else if (active && count == '0 && !load_evt)
      refresh_req <= 1'b1;
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = interval;
      2'd1:    bus_rdata = count;
      2'd2:    bus_rdata = CNT_W'(bank_en);
      default: bus_rdata = '0;
    endcase
  end
endmodule

module refresh_pacer_chk #(
  parameter int CNT_W = 8,
  parameter int BANKS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             bus_we,
  input logic             refresh_req,
  input logic             refresh_done,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] interval,
  input logic [BANKS-1:0] bank_en
);
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req && !refresh_done |=> refresh_req);

  a_r6_stall_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req && !refresh_done && !bus_we |=> $stable(count));

  a_r4_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !bus_we && !(refresh_req && refresh_done) |=> $stable(count));

  a_r7_done_reload: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req && refresh_done && !bus_we |=> !refresh_req && count == $past(interval));

  a_r8_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    bank_en == '0 && !refresh_req |=> !refresh_req);
endmodule

bind refresh_pacer refresh_pacer_chk #(.CNT_W(CNT_W), .BANKS(BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
  .refresh_req(refresh_req), .refresh_done(refresh_done),
  .count(count), .interval(interval), .bank_en(bank_en)
);

// File: tb/tb_refresh_pacer.sv
module tb_refresh_pacer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       refresh_req;
  logic       refresh_done = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_pacer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .refresh_req(refresh_req), .refresh_done(refresh_done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input int exp);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic done_pulse();
    @(negedge clk); refresh_done = 1'b1;
    @(negedge clk); refresh_done = 1'b0;
  endtask

  task automatic t_reset();
    rd_check("R1 interval", 2'd0, 8'hFF);
    rd_check("R1 counter", 2'd1, 8'hFF);
    rd_check("R1 enables", 2'd2, 8'h00);
    check("R1 req", refresh_req, 0);
    rd_check("R2 unused addr", 2'd3, 8'h00);
  endtask

  task automatic t_start_and_count();
    wr(2'd0, 8'h05);
    rd_check("R2 interval readback", 2'd0, 8'h05);
    rd_check("R10 count untouched", 2'd1, 8'hFF);
    ticks(2);
    rd_check("R8 no tick while disabled", 2'd1, 8'hFF);
    wr(2'd2, 8'h01);
    rd_check("R3 load on enable", 2'd1, 8'h05);
    rd_check("R2 enable readback", 2'd2, 8'h01);
    repeat (3) @(negedge clk);
    rd_check("R4 no tick no step", 2'd1, 8'h05);
    ticks(5);
    rd_check("R4 five ticks", 2'd1, 8'h00);
    check("R5 req not yet", refresh_req, 0);
    @(negedge clk);
    check("R5 req raised", refresh_req, 1);
    ticks(3);
    check("R5 req held", refresh_req, 1);
    rd_check("R6 stalled at zero", 2'd1, 8'h00);
    done_pulse();
    check("R7 req dropped", refresh_req, 0);
    rd_check("R7 reloaded", 2'd1, 8'h05);
  endtask

  task automatic t_direct_write();
    wr(2'd1, 8'h03);
    rd_check("R9 overwrite", 2'd1, 8'h03);
    ticks(2);
    rd_check("R9 continue from written", 2'd1, 8'h01);
    wr(2'd0, 8'h09);
    rd_check("R10 interval write no effect", 2'd1, 8'h01);
    ticks(1);
    @(negedge clk);
    check("R5 second req", refresh_req, 1);
    done_pulse();
    rd_check("R10 new interval at reload", 2'd1, 8'h09);
  endtask

  task automatic t_disable();
    wr(2'd2, 8'h00);
    ticks(4);
    rd_check("R8 holds when disabled", 2'd1, 8'h09);
    wr(2'd1, 8'h00);
    repeat (4) @(negedge clk);
    check("R8 no req at zero disabled", refresh_req, 0);
    wr(2'd2, 8'h02);
    rd_check("R3 bank B enable loads", 2'd1, 8'h09);
    ticks(9);
    @(negedge clk);
    check("R5 req via bank B", refresh_req, 1);
    wr(2'd2, 8'h00);
    check("R5 req survives disable", refresh_req, 1);
    done_pulse();
    repeat (4) @(negedge clk);
    check("R8 no new req after done", refresh_req, 0);
    rd_check("R8 reloaded then held", 2'd1, 8'h09);
  endtask

  task automatic t_collision();
    wr(2'd0, 8'h07);
    @(negedge clk); bus_addr = 2'd2; bus_we = 1'b1; bus_wdata = 8'h03; tick = 1'b1;
    @(negedge clk); bus_we = 1'b0; tick = 1'b0;
    rd_check("R11 load beats tick", 2'd1, 8'h07);
    ticks(1);
    rd_check("R4 tick after load", 2'd1, 8'h06);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start_and_count();
    t_direct_write();
    t_disable();
    t_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule